// File: doc/BRIEF.md
# I2C Register-Read Master

This block is a bus master that fetches one or more consecutive bytes from a register inside a 7-bit addressed target. A single strobe on `start` runs the whole exchange. First comes a START and a write-direction address byte. The register pointer byte follows. After that the master issues a repeated START and a read-direction address byte, and then receives as many data bytes as the requested count. The block acknowledges every data byte except the final one. It answers the final byte with a not-acknowledge and closes the bus with a STOP.

Both bus lines are open-drain. The block only pulls SCL or SDA low, through `scl_oe` and `sda_oe`, and releases them otherwise. It samples the resolved SDA level on `sda_in`. Each bit is cut into four quarter phases. Each quarter is `QTR_DIV` system clocks long, so the SCL rate follows from that parameter. A missing acknowledge on either address byte or on the register byte raises `nack_err`. The block then closes with a STOP and reports `done`, and it delivers no data.

Top module: `i2c_regrd_master`

## Requirements
- R1: Out of reset and whenever the block is idle, `scl_oe` and `sda_oe` are both 0 (lines released). `busy`, `done`, `rd_valid` and `nack_err` are all 0 out of reset.
- R2: A transaction begins with a START, followed by the byte `{dev_addr, 1'b0}` shifted out MSB first. A ninth clock then reads the target's acknowledge.
- R3: After the first address byte is acknowledged, the block sends `reg_addr` MSB first and reads its acknowledge.
- R4: After the register byte is acknowledged, the block emits a repeated START, with SDA falling while SCL is high, and no STOP occurs before it.
- R5: After the repeated START, the block sends `{dev_addr, 1'b1}` MSB first and reads its acknowledge.
- R6: Each received byte is assembled MSB first and presented on `rd_data` with `rd_valid` high for exactly one cycle, in bus order, and only while `busy` is high.
- R7: After every received byte except the last, the master pulls SDA low in the ninth clock (ACK). After the last byte it leaves SDA released (NACK) and then issues a STOP.
- R8: SDA changes while SCL is high only to form a START (falling) or a STOP (rising). A normal read therefore shows exactly START, repeated START, STOP on the bus.
- R9: If the target does not acknowledge the write-address byte, the register byte or the read-address byte, `nack_err` is set. The block then issues a STOP, delivers no data and pulses `done`.
- R10: A `byte_cnt` of 0 is treated as 1. The largest count, 2^CNT_W-1, returns that many bytes.
- R11: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse in the cycle that `busy` falls. A `start` while busy is ignored.
- R12: `nack_err` keeps its value until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a read transaction when idle |
| dev_addr | input | 7 | Target device address |
| reg_addr | input | 8 | Register pointer to read from |
| byte_cnt | input | CNT_W | Number of bytes to read (0 means 1) |
| rd_data | output | 8 | Received data byte |
| rd_valid | output | 1 | One-cycle strobe qualifying `rd_data` |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when a transaction ends |
| nack_err | output | 1 | Missing acknowledge on an address or register byte |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
The bench builds the block with `QTR_DIV` = 3 and `CNT_W` = 4. Three-cycle quarters keep a full transaction to a few thousand clocks, so many transactions fit in one run, including a fifteen-byte burst. The 4-bit count makes both ends of the count range reachable: the zero count that must behave as one, and the maximum count of fifteen. A behavioural open-drain target with a self-incrementing, wrapping pointer lets the bench exercise register pointer wrap at 0xFF. It can also refuse any of the three header bytes on demand.

// File: rtl/i2c_regrd_pkg.sv
package i2c_regrd_pkg;

  // Bit-level operations understood by the bus engine.
  typedef enum logic [1:0] {
    OP_BIT   = 2'd0,  // one data/ack slot; txb=1 releases SDA (also used to receive)
    OP_START = 2'd1,  // START or repeated START
    OP_STOP  = 2'd2   // STOP
  } op_e;

  // Sequencer states.
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_TX, S_RSTART, S_RX, S_STOP
  } seq_e;

  // Which header byte is being transmitted.
  typedef enum logic [1:0] {
    B_AW, B_REG, B_AR
  } sel_e;

  // Line drive for one quarter phase.
  typedef struct packed {
    logic scl_keep;  // leave SCL as it is
    logic scl_low;   // pull SCL low
    logic sda_low;   // pull SDA low
  } drv_t;

  // Quarter-phase drive table.
  //  BIT  : SCL low, high, high, low; SDA set in phase 0 while SCL is low.
  //  START: SCL held, then high; SDA drops in phase 2 with SCL high; SCL low.
  //  STOP : SCL low with SDA low, SCL high, SDA rises in phase 2, all free.
  function automatic drv_t phase_drive(op_e op, logic [1:0] ph, logic txb);
    drv_t d;
    d = '0;
    case (op)
      OP_BIT: begin
        d.scl_low = (ph == 2'd0) || (ph == 2'd3);
        d.sda_low = ~txb;
      end
      OP_START: begin
        d.scl_keep = (ph == 2'd0);
        d.scl_low  = (ph == 2'd3);
        d.sda_low  = (ph >= 2'd2);
      end
      OP_STOP: begin
        d.scl_low = (ph == 2'd0);
        d.sda_low = (ph <= 2'd1) && (ph != 2'd3);
      end
      default: d = '0;
    endcase
    return d;
  endfunction

  // Address byte with the direction bit in the LSB (1 = read).
  function automatic logic [7:0] addr_byte(logic [6:0] dev, logic rd);
    return {dev, rd};
  endfunction

endpackage

// File: rtl/i2c_regrd_qtick.sv
module i2c_regrd_qtick #(
  parameter int QTR_DIV = 62
) (
  input  logic clk,
  input  logic rst_n,
  output logic qtick
);
  localparam int CW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;

  generate
    if (QTR_DIV <= 1) begin : g_every
      logic unused_in;
      assign unused_in = clk ^ rst_n;
      assign qtick = 1'b1;
    end else begin : g_div
      logic [CW-1:0] cnt;
      logic          q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
          q   <= 1'b0;
        end else begin
          q   <= (cnt == CW'(QTR_DIV - 1));
          cnt <= (cnt == CW'(QTR_DIV - 1)) ? '0 : cnt + 1'b1;
        end
      end
      assign qtick = q;
    end
  endgenerate

endmodule

// File: rtl/i2c_regrd_bitphy.sv
module i2c_regrd_bitphy
  import i2c_regrd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic qtick,
  input  logic cmd_vld,
  input  op_e  cmd_op,
  input  logic cmd_txb,
  output logic cmd_rdy,
  output logic bit_done,
  output logic rx_bit,
  output op_e  run_op,
  output logic scl_oe,
  output logic sda_oe,
  input  logic sda_in
);
  logic       running;
  op_e        op_q;
  logic       txb_q;
  logic [2:0] step;
  drv_t       drv;

  always_comb drv = phase_drive(op_q, step[1:0], txb_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      op_q     <= OP_BIT;
      txb_q    <= 1'b1;
      step     <= '0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      rx_bit   <= 1'b1;
      bit_done <= 1'b0;
    end else begin
      bit_done <= 1'b0;
      if (!running) begin
        if (cmd_vld) begin
          running <= 1'b1;
          op_q    <= cmd_op;
          txb_q   <= cmd_txb;
          step    <= '0;
        end
      end else if (qtick) begin
        if (!step[2]) begin
          if (!drv.scl_keep) scl_oe <= drv.scl_low;
          sda_oe <= drv.sda_low;
          // entering phase 2: SCL has been released for one quarter
          if (step == 3'd2) rx_bit <= sda_in;
          step <= step + 1'b1;
        end else begin
          running  <= 1'b0;
          bit_done <= 1'b1;
        end
      end
    end
  end

  assign cmd_rdy = ~running;
  assign run_op  = op_q;

endmodule

// File: rtl/i2c_regrd_master.sv
module i2c_regrd_master
  import i2c_regrd_pkg::*;
#(
  parameter int QTR_DIV = 62,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [6:0]       dev_addr,
  input  logic [7:0]       reg_addr,
  input  logic [CNT_W-1:0] byte_cnt,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             busy,
  output logic             done,
  output logic             nack_err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // Internal events, named so the checker can watch them.
  logic       qtick;
  logic       eng_rdy;
  logic       bit_done;
  logic       rx_bit;
  op_e        run_op;
  op_e        cmd_op;
  logic       cmd_txb;
  logic       cmd_vld;
  logic       last_byte;

  seq_e             st;
  sel_e             sel;
  logic             issued;
  logic [6:0]       dev_q;
  logic [7:0]       reg_q;
  logic [7:0]       shreg;
  logic [3:0]       idx;
  logic [CNT_W-1:0] remaining;

  i2c_regrd_qtick #(.QTR_DIV(QTR_DIV)) u_qtick (
    .clk  (clk),
    .rst_n(rst_n),
    .qtick(qtick)
  );

  i2c_regrd_bitphy u_phy (
    .clk     (clk),
    .rst_n   (rst_n),
    .qtick   (qtick),
    .cmd_vld (cmd_vld),
    .cmd_op  (cmd_op),
    .cmd_txb (cmd_txb),
    .cmd_rdy (eng_rdy),
    .bit_done(bit_done),
    .rx_bit  (rx_bit),
    .run_op  (run_op),
    .scl_oe  (scl_oe),
    .sda_oe  (sda_oe),
    .sda_in  (sda_in)
  );

  assign last_byte = (remaining == ONE);

  // Command for the current state; idx 8 is the acknowledge slot.
  always_comb begin
    cmd_op  = OP_BIT;
    cmd_txb = 1'b1;
    case (st)
      S_START, S_RSTART: cmd_op = OP_START;
      S_STOP:            cmd_op = OP_STOP;
      S_TX:              cmd_txb = idx[3] ? 1'b1 : shreg[7];
      S_RX:              cmd_txb = idx[3] ? last_byte : 1'b1;
      default:           cmd_op = OP_BIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sel       <= B_AW;
      issued    <= 1'b0;
      cmd_vld   <= 1'b0;
      dev_q     <= '0;
      reg_q     <= '0;
      shreg     <= '0;
      idx       <= '0;
      remaining <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      done      <= 1'b0;
      nack_err  <= 1'b0;
    end else begin
      cmd_vld  <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          dev_q     <= dev_addr;
          reg_q     <= reg_addr;
          remaining <= (byte_cnt == '0) ? ONE : byte_cnt;
          nack_err  <= 1'b0;
          issued    <= 1'b0;
          st        <= S_START;
        end
      end else if (!issued) begin
        if (eng_rdy) begin
          cmd_vld <= 1'b1;
          issued  <= 1'b1;
        end
      end else if (bit_done) begin
        issued <= 1'b0;
        case (st)
          S_START: begin
            st    <= S_TX;
            sel   <= B_AW;
            shreg <= addr_byte(dev_q, 1'b0);
            idx   <= '0;
          end
          S_TX: begin
            if (!idx[3]) begin
              shreg <= {shreg[6:0], 1'b0};
              idx   <= idx + 1'b1;
            end else if (rx_bit) begin
              nack_err <= 1'b1;
              st       <= S_STOP;
            end else begin
              idx <= '0;
              case (sel)
                B_AW: begin
                  shreg <= reg_q;
                  sel   <= B_REG;
                end
                B_REG:   st <= S_RSTART;
                default: begin
                  st    <= S_RX;
                  shreg <= '0;
                end
              endcase
            end
          end
          S_RSTART: begin
            st    <= S_TX;
            sel   <= B_AR;
            shreg <= addr_byte(dev_q, 1'b1);
            idx   <= '0;
          end
          S_RX: begin
            if (!idx[3]) begin
              shreg <= {shreg[6:0], rx_bit};
              idx   <= idx + 1'b1;
              if (idx == 4'd7) begin
                rd_data  <= {shreg[6:0], rx_bit};
                rd_valid <= 1'b1;
              end
            end else if (last_byte) begin
              st <= S_STOP;
            end else begin
              remaining <= remaining - ONE;
              idx       <= '0;
            end
          end
          S_STOP: begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign busy = (st != S_IDLE);

endmodule

// File: rtl/i2c_regrd_checker.sv
module i2c_regrd_checker
  import i2c_regrd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       rd_valid,
  input logic       nack_err,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [1:0] run_op
);

  a_r1_idle_lines_free: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  a_r8_start_edge_in_start_op: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $rose(sda_oe)) |-> (run_op == OP_START));

  a_r8_stop_edge_in_stop_op: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && $past(!scl_oe) && $fell(sda_oe)) |-> (run_op == OP_STOP));

  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r6_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  a_r11_done_drops_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_busy_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r11_start_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  a_r9_err_rises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack_err) |-> busy);

endmodule

bind i2c_regrd_master i2c_regrd_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .rd_valid(rd_valid),
  .nack_err(nack_err),
  .scl_oe  (scl_oe),
  .sda_oe  (sda_oe),
  .run_op  (run_op)
);

// File: tb/i2c_regrd_master_bench.sv
module i2c_regrd_master_bench;
  localparam int         QD   = 3;
  localparam int         CW   = 4;
  localparam logic [6:0] TADR = 7'h50;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [6:0]    dev_addr = '0;
  logic [7:0]    reg_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic [7:0]    rd_data;
  logic          rd_valid, busy, done, nack_err, scl_oe, sda_oe;
  logic          sda_line, scl_line;
  logic          t_sda_oe = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | t_sda_oe);

  i2c_regrd_master #(.QTR_DIV(QD), .CNT_W(CW)) u_i2c_regrd_master (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr),
    .reg_addr(reg_addr), .byte_cnt(byte_cnt), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .done(done), .nack_err(nack_err),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  function automatic logic [7:0] regf(input logic [7:0] a);
    return a * 8'd29 + 8'h4B;
  endfunction

  // Behavioural target and bus log
  logic       clr_req = 1'b0;
  int         t_nack_at = 99;
  logic       t_prev_scl = 1'b1, t_prev_sda = 1'b1, t_first = 1'b0, t_ack = 1'b0;
  logic       prev_valid = 1'b0;
  int         t_mode = 0, t_rise = 0;
  logic [7:0] t_sh = '0, t_ptr = '0, t_data = '0;
  int         lg_bytes [0:7];
  int         lg_ev    [0:7];
  int         lg_mack  [0:15];
  int         lg_dout  [0:15];
  int         lg_nbytes = 0, lg_nev = 0, lg_nmack = 0, lg_ndout = 0, lg_ndone = 0, lg_vlong = 0;

  always @(negedge clk) begin
    if (!rst_n || clr_req) begin
      lg_nbytes = 0; lg_nev = 0; lg_nmack = 0; lg_ndout = 0; lg_ndone = 0; lg_vlong = 0;
      t_mode = 0; t_rise = 0; t_sda_oe = 1'b0; t_prev_scl = 1'b1; t_prev_sda = 1'b1;
      prev_valid = 1'b0;
    end else begin
      if (t_prev_scl && scl_line && t_prev_sda && !sda_line) begin
        if (lg_nev < 8) lg_ev[lg_nev] = 1;
        lg_nev++; t_mode = 1; t_rise = 0; t_first = 1'b1; t_sda_oe = 1'b0;
      end else if (t_prev_scl && scl_line && !t_prev_sda && sda_line) begin
        if (lg_nev < 8) lg_ev[lg_nev] = 2;
        lg_nev++; t_mode = 0; t_sda_oe = 1'b0;
      end else if (!t_prev_scl && scl_line) begin
        t_rise++;
        if (t_mode == 1 && t_rise <= 8) t_sh = {t_sh[6:0], sda_line};
        if (t_mode == 2 && t_rise == 9) begin
          if (lg_nmack < 16) lg_mack[lg_nmack] = int'(sda_line);
          lg_nmack++;
        end
      end else if (t_prev_scl && !scl_line) begin
        if (t_mode == 1) begin
          if (t_rise == 8) begin
            if (t_first) t_ack = (t_sh[7:1] == TADR) && (lg_nbytes != t_nack_at);
            else         t_ack = (lg_nbytes != t_nack_at);
            if (lg_nbytes < 8) lg_bytes[lg_nbytes] = int'(t_sh);
            lg_nbytes++;
            t_sda_oe = t_ack;
          end else if (t_rise == 9) begin
            t_sda_oe = 1'b0; t_rise = 0;
            if (!t_ack) t_mode = 0;
            else if (t_first && t_sh[0]) begin
              t_mode = 2; t_data = regf(t_ptr); t_sda_oe = ~t_data[7];
            end else if (t_first) t_first = 1'b0;
            else t_ptr = t_sh;
          end
        end else if (t_mode == 2) begin
          if (t_rise >= 1 && t_rise <= 7) t_sda_oe = ~t_data[7 - t_rise];
          else if (t_rise == 8) t_sda_oe = 1'b0;
          else if (t_rise == 9) begin
            t_rise = 0;
            if (lg_mack[lg_nmack-1] == 0) begin
              t_ptr = t_ptr + 8'd1; t_data = regf(t_ptr); t_sda_oe = ~t_data[7];
            end else t_mode = 0;
          end
        end
      end
      t_prev_scl = scl_line; t_prev_sda = sda_line;
      if (rd_valid) begin
        if (lg_ndout < 16) lg_dout[lg_ndout] = int'(rd_data);
        lg_ndout++;
        if (prev_valid) lg_vlong++;
      end
      prev_valid = rd_valid;
      if (done) lg_ndone++;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_txn(input logic [6:0] dv, input logic [7:0] ra, input logic [CW-1:0] bc,
                        input int nk, input int poke);
    @(posedge clk); #1 clr_req = 1'b1; t_nack_at = nk;
    @(posedge clk); #1 clr_req = 1'b0;
    dev_addr = dv; reg_addr = ra; byte_cnt = bc; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    eq("R11 busy after start", int'(busy), 1);
    if (poke > 0) begin
      repeat (poke) @(posedge clk);
      #1 dev_addr = 7'h33; reg_addr = 8'h00; byte_cnt = '0; start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      eq("R11 still busy after ignored start", int'(busy), 1);
    end
    for (int w = 0; w < 20000 && lg_ndone == 0; w++) @(negedge clk);
    @(negedge clk);
    eq("R11 single done pulse", lg_ndone, 1);
    eq("R11 idle after done", int'(busy), 0);
    eq("R1 lines released when idle", int'(scl_oe | sda_oe), 0);
  endtask

  task automatic check_header(input logic [6:0] dv, input logic [7:0] ra);
    eq("R2 write address byte", lg_bytes[0], int'({dv, 1'b0}));
    eq("R3 register byte", lg_bytes[1], int'(ra));
    eq("R5 read address byte", lg_bytes[2], int'({dv, 1'b1}));
    eq("R4 first event START", lg_ev[0], 1);
    eq("R4 second event repeated START", lg_ev[1], 1);
    eq("R8 bus event count", lg_nev, 3);
    eq("R7 closing STOP", lg_ev[2], 2);
  endtask

  task automatic check_data(input logic [7:0] ra, input int n);
    eq("R6 data byte count", lg_ndout, n);
    eq("R6 valid one cycle", lg_vlong, 0);
    for (int i = 0; i < n && i < 16; i++) begin
      eq("R6 data byte value", lg_dout[i], int'(regf(ra + 8'(i))));
      eq("R7 master ack/nack", lg_mack[i], (i == n - 1) ? 1 : 0);
    end
    eq("R9 no error", int'(nack_err), 0);
  endtask

  task automatic t_reset_state;
    eq("R1 scl_oe at reset", int'(scl_oe), 0);
    eq("R1 sda_oe at reset", int'(sda_oe), 0);
    eq("R1 busy at reset", int'(busy), 0);
    eq("R1 done/valid/err at reset", int'(done | rd_valid | nack_err), 0);
  endtask

  task automatic t_single;
    do_txn(TADR, 8'h10, 4'd1, 99, 0);
    check_header(TADR, 8'h10);
    check_data(8'h10, 1);
  endtask

  task automatic t_burst;
    do_txn(TADR, 8'h20, 4'd4, 99, 0);
    check_header(TADR, 8'h20);
    check_data(8'h20, 4);
  endtask

  task automatic t_wrap;
    do_txn(TADR, 8'hFE, 4'd3, 99, 0);
    check_header(TADR, 8'hFE);
    check_data(8'hFE, 3);
  endtask

  task automatic t_max_count;
    do_txn(TADR, 8'h80, 4'd15, 99, 0);
    check_header(TADR, 8'h80);
    eq("R10 maximum count", lg_ndout, 15);
    check_data(8'h80, 15);
  endtask

  task automatic t_zero_count;
    do_txn(TADR, 8'h05, 4'd0, 99, 0);
    check_header(TADR, 8'h05);
    eq("R10 zero count reads one", lg_ndout, 1);
    check_data(8'h05, 1);
  endtask

  task automatic t_nack_addr;
    do_txn(7'h33, 8'h10, 4'd2, 99, 0);
    eq("R9 error on address nack", int'(nack_err), 1);
    eq("R9 one byte sent", lg_nbytes, 1);
    eq("R9 events START,STOP", lg_nev, 2);
    eq("R9 STOP after nack", lg_ev[1], 2);
    eq("R9 no data", lg_ndout, 0);
  endtask

  task automatic t_nack_reg;
    do_txn(TADR, 8'h10, 4'd2, 1, 0);
    eq("R9 error on register nack", int'(nack_err), 1);
    eq("R9 two bytes sent", lg_nbytes, 2);
    eq("R9 events START,STOP", lg_nev, 2);
    eq("R9 no data", lg_ndout, 0);
  endtask

  task automatic t_nack_read_addr;
    do_txn(TADR, 8'h10, 4'd2, 2, 0);
    eq("R9 error on read address nack", int'(nack_err), 1);
    eq("R9 three bytes sent", lg_nbytes, 3);
    eq("R9 events START,RSTART,STOP", lg_nev, 3);
    eq("R9 STOP last", lg_ev[2], 2);
    eq("R9 no data", lg_ndout, 0);
  endtask

  task automatic t_err_clears;
    do_txn(TADR, 8'h33, 4'd1, 99, 0);
    eq("R12 error cleared by new start", int'(nack_err), 0);
    check_data(8'h33, 1);
  endtask

  task automatic t_busy_ignore;
    do_txn(TADR, 8'h40, 4'd2, 99, 100);
    check_header(TADR, 8'h40);
    check_data(8'h40, 2);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(posedge clk);
        #1;
        t_reset_state();
        rst_n = 1'b1;
        t_single();
        t_burst();
        t_wrap();
        t_nack_addr();
        t_err_clears();
        t_nack_reg();
        t_nack_read_addr();
        t_zero_count();
        t_max_count();
        t_busy_ignore();
        repeat (10) @(posedge clk);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule